// File: doc/BRIEF.md
# FM Channel Timer-Driven Keying Controller

This block owns the key state of the single FM channel that can be keyed automatically by the first interval timer. It takes a two-bit channel mode field, the timer's run bit and its one-cycle expiry pulse, together with manual keying writes. From these it produces per-operator key-on and key-off event strobes for the envelope generators. It also produces a flag that tells the frequency path to give each operator its own frequency.

When automatic keying is armed, each timer expiry sends the channel a key-on and then a key-off, as two consecutive single-cycle strobes. This lets a downstream envelope generator start each operator at its total level and release it at once. Operators that software has keyed on by hand are excluded from automatic keying until software keys them off again. The arming condition is sampled at the expiry itself, not when the timer is started.

Top module: `fm_autokey_ctl`

## Requirements
- R1: While rst_ni is low and on the first cycle after reset, key_on_o and key_off_o are 0000 and every operator is released (not held).
- R2: The mode field decodes as 00 normal, 01 per-operator frequency, 10 per-operator frequency with automatic keying, 11 per-operator frequency. per_op_freq_o is 1 for 01, 10 and 11, and 0 for 00.
- R3: Automatic keying is armed only when mode_i is 10 and tmr_run_i is 1. An expiry under any other combination produces no strobe.
- R4: An armed expiry sampled at clock edge t sets key_on_o to the mask of non-held operators for the cycle after t. key_off_o carries the same mask for the cycle after that.
- R5: Arming is evaluated at each expiry. A mode change made between two expiries governs the second expiry.
- R6: A manual write (key_wr_i high) sets each operator's hold to bit i of key_sel_i (1 = key on, 0 = key off). Operators whose hold goes 0 to 1 get a key_on_o strobe and operators going 1 to 0 get a key_off_o strobe, one cycle after the write. Rewriting an unchanged hold produces no strobe.
- R7: Automatic keying never strobes a held operator. With all four operators held, an armed expiry produces no strobe at all.
- R8: After a manual key-off releases an operator, the next armed expiry keys it on and off again.
- R9: When a manual write and an armed expiry share a cycle, the write is applied first and the automatic mask uses the updated hold. An operator released by that write gets only the automatic on/off pair, not a separate manual key-off strobe.
- R10: key_on_o and key_off_o are never both 1 for the same operator in the same cycle.
- R11: When armed expiries arrive on consecutive cycles, each produces a key-on in the following cycle. The key-off is issued once, in the cycle after the last key-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel mode field |
| tmr_run_i | input | 1 | Interval timer run (load) bit |
| tmr_expire_i | input | 1 | One-cycle timer expiry pulse |
| key_wr_i | input | 1 | Manual keying write strobe |
| key_sel_i | input | 4 | Per-operator key state for a manual write, 1 = on |
| key_on_o | output | 4 | Per-operator key-on event strobes |
| key_off_o | output | 4 | Per-operator key-off event strobes |
| per_op_freq_o | output | 1 | Use per-operator frequencies |

## Verification
Every cycle, the assertions check that key-on and key-off are disjoint per operator. They also check that an unarmed expiry without a write gives no key-on, that an armed expiry keys on exactly the unheld operators, that the key-off follows one cycle later, and that held operators never receive a key-on. The bench covers the behaviours that depend on history or ordering. It sweeps every mode, run bit and hold pattern, and it also covers mode changes between expiries, hold release, a write and an expiry in the same cycle, and back-to-back expiries.

// File: rtl/fm_autokey_pkg.sv
package fm_autokey_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CHM_NORMAL     = 2'b00,
    CHM_SPLIT      = 2'b01,
    CHM_SPLIT_AUTO = 2'b10,
    CHM_SPLIT_ALT  = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/fm_autokey_mode_dec.sv
module fm_autokey_mode_dec
  import fm_autokey_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              tmr_run_i,
  output logic              per_op_freq_o,
  output logic              auto_arm_o
);
  ch_mode_e mode;
  assign mode = ch_mode_e'(mode_i);

  always_comb begin
    per_op_freq_o = 1'b0;
    auto_arm_o    = 1'b0;
    unique case (mode)
      CHM_NORMAL:     per_op_freq_o = 1'b0;
      CHM_SPLIT:      per_op_freq_o = 1'b1;
      CHM_SPLIT_AUTO: begin
        per_op_freq_o = 1'b1;
        auto_arm_o    = tmr_run_i;
      end
      CHM_SPLIT_ALT:  per_op_freq_o = 1'b1;
      default:        per_op_freq_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fm_autokey_hold.sv
module fm_autokey_hold #(
  parameter int unsigned NOPS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NOPS-1:0] sel_i,
  output logic [NOPS-1:0] hold_q_o,
  output logic [NOPS-1:0] hold_d_o,
  output logic [NOPS-1:0] rise_o,
  output logic [NOPS-1:0] fall_o
);
  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic q;
    logic d;
    assign d = wr_i ? sel_i[g] : q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= d;
    end
    assign hold_q_o[g] = q;
    assign hold_d_o[g] = d;
    assign rise_o[g]   = d & ~q;
    assign fall_o[g]   = q & ~d;
  end
endmodule

// File: rtl/fm_autokey_seq.sv
module fm_autokey_seq #(
  parameter int unsigned NOPS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [NOPS-1:0] hold_d_i,
  input  logic [NOPS-1:0] rise_i,
  input  logic [NOPS-1:0] fall_i,
  output logic [NOPS-1:0] key_on_o,
  output logic [NOPS-1:0] key_off_o
);
  logic [NOPS-1:0] auto_on;
  logic [NOPS-1:0] pend_q;
  logic [NOPS-1:0] on_d, off_d;
  logic [NOPS-1:0] on_q, off_q;

  // automatic events only reach operators free after this cycle's write
  assign auto_on = {NOPS{fire_i}} & ~hold_d_i;
  assign on_d    = rise_i | auto_on;
  // a fresh auto key-on supersedes any off due now; its own off follows
  assign off_d   = (fall_i | pend_q) & ~auto_on & ~hold_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      on_q   <= '0;
      off_q  <= '0;
    end else begin
      pend_q <= auto_on;
      on_q   <= on_d;
      off_q  <= off_d;
    end
  end

  assign key_on_o  = on_q;
  assign key_off_o = off_q;
endmodule

// File: rtl/fm_autokey_ctl.sv
module fm_autokey_ctl
  import fm_autokey_pkg::*;
#(
  parameter int unsigned NOPS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic            tmr_run_i,
  input  logic            tmr_expire_i,
  input  logic            key_wr_i,
  input  logic [NOPS-1:0] key_sel_i,
  output logic [NOPS-1:0] key_on_o,
  output logic [NOPS-1:0] key_off_o,
  output logic            per_op_freq_o
);
  logic            auto_arm;
  logic [NOPS-1:0] hold_q, hold_d, rise, fall;

  fm_autokey_mode_dec u_dec (
    .mode_i        (mode_i),
    .tmr_run_i     (tmr_run_i),
    .per_op_freq_o (per_op_freq_o),
    .auto_arm_o    (auto_arm)
  );

  fm_autokey_hold #(.NOPS(NOPS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (key_wr_i),
    .sel_i    (key_sel_i),
    .hold_q_o (hold_q),
    .hold_d_o (hold_d),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  fm_autokey_seq #(.NOPS(NOPS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (tmr_expire_i & auto_arm),
    .hold_d_i  (hold_d),
    .rise_i    (rise),
    .fall_i    (fall),
    .key_on_o  (key_on_o),
    .key_off_o (key_off_o)
  );
endmodule

// File: rtl/fm_autokey_chk.sv
module fm_autokey_chk #(
  parameter int unsigned NOPS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic            tmr_run_i,
  input logic            tmr_expire_i,
  input logic            key_wr_i,
  input logic [NOPS-1:0] hold_q,
  input logic [NOPS-1:0] key_on_o,
  input logic [NOPS-1:0] key_off_o
);
  logic armed;
  assign armed = (mode_i == 2'b10) && tmr_run_i;

  AST_ON_OFF_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_on_o & key_off_o) == '0); // R10

  AST_UNARMED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_expire_i && !armed && !key_wr_i) |=> key_on_o == '0); // R3

  AST_ARMED_KEYON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_expire_i && armed && !key_wr_i) |=> key_on_o == ~$past(hold_q)); // R4

  AST_ARMED_KEYOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_expire_i && armed && !key_wr_i) ##1 (!key_wr_i && !tmr_expire_i)
      |=> key_off_o == ~hold_q); // R4

  AST_HELD_NO_KEYON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_wr_i |=> (key_on_o & hold_q) == '0); // R7
endmodule

bind fm_autokey_ctl fm_autokey_chk #(.NOPS(NOPS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .tmr_run_i    (tmr_run_i),
  .tmr_expire_i (tmr_expire_i),
  .key_wr_i     (key_wr_i),
  .hold_q       (hold_q),
  .key_on_o     (key_on_o),
  .key_off_o    (key_off_o)
);

// File: tb/sim_fm_autokey_ctl.sv
module sim_fm_autokey_ctl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       tmr_run_i = 1'b0;
  logic       tmr_expire_i = 1'b0;
  logic       key_wr_i = 1'b0;
  logic [3:0] key_sel_i = 4'h0;
  logic [3:0] key_on_o, key_off_o;
  logic       per_op_freq_o;

  int vectors = 0;
  int errors  = 0;
  logic [3:0] hold_m = 4'h0;

  always #4 clk_i = ~clk_i;

  fm_autokey_ctl u0 (
    .clk_i, .rst_ni, .mode_i, .tmr_run_i, .tmr_expire_i,
    .key_wr_i, .key_sel_i, .key_on_o, .key_off_o, .per_op_freq_o
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // manual write, then check the transition strobes one cycle later
  task automatic man_write(input logic [3:0] sel);
    logic [3:0] prev;
    prev = hold_m;
    key_wr_i = 1'b1; key_sel_i = sel;
    @(negedge clk_i);
    key_wr_i = 1'b0;
    hold_m = sel;
    chk("R6 manual on", key_on_o, sel & ~prev);
    chk("R6 manual off", key_off_o, prev & ~sel);
    @(negedge clk_i);
  endtask

  task automatic expire(input logic [1:0] m, input logic run);
    logic [3:0] exp;
    mode_i = m; tmr_run_i = run;
    exp = (m == 2'b10 && run) ? ~hold_m : 4'h0;
    tmr_expire_i = 1'b1;
    @(negedge clk_i);
    tmr_expire_i = 1'b0;
    chk("R3 R4 R7 expiry key-on", key_on_o, exp);
    chk("R10 no off with on", key_off_o, 4'h0);
    @(negedge clk_i);
    chk("R4 R7 expiry key-off", key_off_o, exp);
    chk("R4 no second on", key_on_o, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 reset on", key_on_o, 4'h0);
    chk("R1 reset off", key_off_o, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset on", key_on_o, 4'h0);
    chk("R1 after reset off", key_off_o, 4'h0);

    // R2 decode of each mode value
    for (int m = 0; m < 4; m++) begin
      mode_i = m[1:0];
      #1;
      chk("R2 per-op freq", {3'b000, per_op_freq_o}, {3'b000, m != 0});
    end
    @(negedge clk_i);

    // sweep: every hold pattern x mode x run bit
    for (int h = 0; h < 16; h++) begin
      man_write(h[3:0]);
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 2; r++)
          expire(m[1:0], r[0]);
    end

    // R6 rewrite with no change gives no strobe
    man_write(4'b1010);
    man_write(4'b1010);

    // R5 mode change between expiries; R8 release re-enables
    man_write(4'b0000);
    expire(2'b10, 1'b1);
    expire(2'b11, 1'b1);
    expire(2'b10, 1'b1);
    man_write(4'b1111);
    expire(2'b10, 1'b1);   // R7 all held: nothing
    man_write(4'b0110);    // R8 release ops 0 and 3
    expire(2'b10, 1'b1);

    // R9 write and expiry in the same cycle, releasing ops 2,3
    man_write(4'b1111);
    mode_i = 2'b10; tmr_run_i = 1'b1;
    key_wr_i = 1'b1; key_sel_i = 4'b0011; tmr_expire_i = 1'b1;
    @(negedge clk_i);
    key_wr_i = 1'b0; tmr_expire_i = 1'b0; hold_m = 4'b0011;
    chk("R9 same-cycle release on", key_on_o, 4'b1100);
    chk("R9 no manual off", key_off_o, 4'b0000);
    @(negedge clk_i);
    chk("R9 same-cycle release off", key_off_o, 4'b1100);
    @(negedge clk_i);

    // R9 write keying op0 on in the expiry cycle
    man_write(4'b0000);
    key_wr_i = 1'b1; key_sel_i = 4'b0001; tmr_expire_i = 1'b1;
    @(negedge clk_i);
    key_wr_i = 1'b0; tmr_expire_i = 1'b0; hold_m = 4'b0001;
    chk("R9 same-cycle hold on", key_on_o, 4'b1111);
    @(negedge clk_i);
    chk("R9 same-cycle hold off", key_off_o, 4'b1110);
    @(negedge clk_i);

    // R11 back-to-back expiries
    man_write(4'b0000);
    tmr_expire_i = 1'b1;
    @(negedge clk_i);
    chk("R11 first on", key_on_o, 4'b1111);
    @(negedge clk_i);
    tmr_expire_i = 1'b0;
    chk("R11 second on", key_on_o, 4'b1111);
    chk("R11 merged off", key_off_o, 4'b0000);
    @(negedge clk_i);
    chk("R11 final off", key_off_o, 4'b1111);
    chk("R11 quiet on", key_on_o, 4'b0000);
    @(negedge clk_i);
    chk("R10 idle off", key_off_o, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule